// File: doc/BRIEF.md
# SPI Master with Interrupt Summary

This block is a byte-wide SPI master for a microcontroller-style peripheral bus. Software writes a byte to the data register. The block shifts that byte out on MOSI, most significant bit first, and captures the same number of bits from MISO. When the frame ends, software reads the received byte from the same address. The serial clock comes from the system clock through a fixed, parameterised divider. A control register selects the idle level of the serial clock, the edge on which data is launched and the edge on which it is sampled.

Three status flags describe what happened:
- a frame-done flag;
- a collision flag, set when the data register is written in the middle of a frame;
- a fault flag, set by an external mode-fault input.

A read-only summary flag is built from these three flags. It is set by the done flag or the collision flag, and it falls only when all three flags are clear. It never depends on the interrupt enables. The interrupt request to the processor is the summary flag qualified by a local enable bit and by a chip-wide global enable input.

Register map. The register address is `addr`.
- 0 is control: bit0 idle clock level, bit1 phase, bit2 local interrupt enable.
- 1 is status: bit0 done, bit1 collision, bit2 fault, bit3 busy, bit4 summary.
- 2 is data.
- 3 reads as zero.

Top module: `spi_irq_master`

## Requirements
- R1: After reset, control and status read 0, data reads 0, SCLK is 0, MOSI is 0 and IRQ is 0.
- R2: A write to address 2 while idle starts an 8-bit frame that sends the byte MSB first. Status bit3 (busy) reads 1 for the whole frame.
- R3: The 8 bits sampled from MISO, first sample as MSB, are readable at address 2 once busy falls. This holds in all four clock modes.
- R4: SCLK rests at control bit0 when idle. With control bit1 = 1, MOSI changes on the first edge of each bit and MISO is sampled on the second edge. With bit1 = 0, the first bit is valid before the first edge, sampling is on the first edge and MOSI changes on the second.
- R5: One SCLK period lasts DIV system clocks, where DIV is an even parameter of at least 4. Busy is therefore high for exactly 8·DIV clocks per frame.
- R6: Status bit0 (done) and bit4 (summary) rise on the clock where the final SCLK edge of the frame is made. This is DIV/2 clocks after the eighth leading SCLK edge, so 2 clocks at the default divider.
- R7: A write to address 2 while busy sets status bit1 (collision) and does not change the frame in progress: not its data, not its length, not the received byte.
- R8: Writing 1 to status bit0, bit1 or bit2 clears that flag, and writing 0 leaves it alone. A set and a clear of the same flag in the same clock leave the flag set.
- R9: `fault_in` high at a clock edge sets status bit2 (fault). This flag alone never sets the summary.
- R10: The summary is set when done or collision is set. It holds while any of the three flags remains set and drops once all three are clear. Writes to bit4 have no effect.
- R11: The summary updates whether or not the local interrupt enable (control bit2) is set.
- R12: IRQ is 1 exactly when the summary, control bit2 and `glb_ie` are all 1.
- R13: Writes to the control register while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Register read data, combinational from addr |
| glb_ie | input | 1 | Global interrupt enable |
| fault_in | input | 1 | Mode-fault event input |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| irq | output | 1 | Interrupt request to the processor |

## Verification
A wrong phase or edge counter shows in two places. The busy window would differ from 8·DIV clocks, and the bits the slave model gathers would be shifted or mis-ordered; both are visible within the frame where the fault occurs. A wrong summary state shows at the status read and on IRQ within one clock of the flag change that should move it. The bench walks the summary through each set, hold and release path. A collision that disturbs the engine shows as a corrupted byte at the slave or a frame of the wrong length.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
   // register addresses
   localparam int ADDR_CTRL = 0;
   localparam int ADDR_STAT = 1;
   localparam int ADDR_DATA = 2;

   // control bit positions
   localparam int CTL_CPOL = 0;
   localparam int CTL_CPHA = 1;
   localparam int CTL_IE   = 2;

   // status bit positions; flag indices 0..2 match the flag vector
   localparam int ST_DONE = 0;
   localparam int ST_WCOL = 1;
   localparam int ST_FLT  = 2;
   localparam int ST_BUSY = 3;
   localparam int ST_SUM  = 4;

   localparam int NFLAG = 3;

   typedef struct packed {
      logic ie;
      logic cpha;
      logic cpol;
   } spi_ctrl_t;
endpackage

// File: rtl/spi_irq_clkgen.sv
module spi_irq_clkgen #(
   parameter int DIV    = 4,
   parameter int DATA_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic cpol,
   output logic busy,
   output logic sclk,
   output logic lead,
   output logic trail,
   output logic last
);
   localparam int HALF  = DIV / 2;
   localparam int NEDGE = 2 * DATA_W;
   localparam int CW    = $clog2(HALF > 1 ? HALF : 2);
   localparam int EW    = $clog2(NEDGE + 1);

   logic [CW-1:0] cnt_q;
   logic [EW-1:0] edge_q;
   logic          busy_q;
   logic          ph_q;
   logic          tick;

   assign tick  = busy_q && (cnt_q == CW'(HALF - 1));
   assign lead  = tick && !edge_q[0];
   assign trail = tick && edge_q[0];
   assign last  = tick && (edge_q == EW'(NEDGE - 1));
   assign busy  = busy_q;
   assign sclk  = cpol ^ ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         edge_q <= '0;
         busy_q <= 1'b0;
         ph_q   <= 1'b0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            edge_q <= '0;
            ph_q   <= 1'b0;
         end
      end else if (tick) begin
         cnt_q  <= '0;
         edge_q <= edge_q + EW'(1);
         ph_q   <= ~ph_q;
         if (last) busy_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   // R5: never more than 2*DATA_W edges in one frame
   a_r5_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (edge_q < EW'(NEDGE)));
   // R4: the clock phase is back at rest whenever the engine is idle
   a_r4_idle_phase: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !ph_q);
endmodule

// File: rtl/spi_irq_shift.sv
module spi_irq_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] wdata,
   input  logic              cpha,
   input  logic              lead,
   input  logic              trail,
   input  logic              last,
   input  logic              miso,
   output logic              mosi,
   output logic [DATA_W-1:0] rx_data
);
   logic [DATA_W-1:0] tx_q;
   logic [DATA_W-1:0] rx_q;
   logic [DATA_W-1:0] rxb_q;
   logic              mosi_q;
   logic              launch;
   logic              sample;

   // phase 1 launches on leading edges, phase 0 on trailing ones except the last
   assign launch = cpha ? lead : (trail && !last);
   assign sample = cpha ? trail : lead;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q   <= '0;
         mosi_q <= 1'b0;
      end else if (start) begin
         if (cpha) begin
            tx_q <= wdata;
         end else begin
            mosi_q <= wdata[DATA_W-1];
            tx_q   <= {wdata[DATA_W-2:0], 1'b0};
         end
      end else if (launch) begin
         mosi_q <= tx_q[DATA_W-1];
         tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q  <= '0;
         rxb_q <= '0;
      end else begin
         if (sample) rx_q <= {rx_q[DATA_W-2:0], miso};
         if (last) rxb_q <= cpha ? {rx_q[DATA_W-2:0], miso} : rx_q;
      end
   end

   assign mosi    = mosi_q;
   assign rx_data = rxb_q;
endmodule

// File: rtl/spi_irq_flags.sv
module spi_irq_flags #(
   parameter int             NF       = 3,
   parameter logic [NF-1:0]  SUM_MASK = 3'b011
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] set_i,
   input  logic [NF-1:0] clr_i,
   input  logic          ie,
   input  logic          glb_ie,
   output logic [NF-1:0] flag_o,
   output logic          sum_o,
   output logic          irq_o
);
   logic [NF-1:0] flag_q;
   logic [NF-1:0] nxt;
   logic          sum_q;
   logic          sum_nxt;

   for (genvar i = 0; i < NF; i++) begin : g_flag
      assign nxt[i] = set_i[i] | (flag_q[i] & ~clr_i[i]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q[i] <= 1'b0;
         else        flag_q[i] <= nxt[i];
      end

      // R8: a set in a cycle always lands, even against a clear
      a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> flag_q[i]);
   end

   always_comb begin
      if (|(nxt & SUM_MASK)) sum_nxt = 1'b1;
      else if (|nxt)         sum_nxt = sum_q;
      else                   sum_nxt = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sum_q <= 1'b0;
      else        sum_q <= sum_nxt;
   end

   assign flag_o = flag_q;
   assign sum_o  = sum_q;
   assign irq_o  = sum_q & ie & glb_ie;

   // R10: summary is never up with every flag down
   a_r10_sum_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      sum_q |-> (|flag_q));
   // R10, R9: summary only rises with a summary-class flag present
   a_r10_sum_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sum_q) |-> (|(flag_q & SUM_MASK)));
endmodule

// File: rtl/spi_irq_master.sv
module spi_irq_master #(
   parameter int DATA_W = 8,
   parameter int DIV    = 4,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              glb_ie,
   input  logic              fault_in,
   input  logic              miso,
   output logic              sclk,
   output logic              mosi,
   output logic              irq
);
   import spi_irq_pkg::*;

   if (DIV < 4 || (DIV % 2) != 0) begin : g_bad_div
      $error("DIV must be even and at least 4");
   end
   if (DATA_W < 5) begin : g_bad_width
      $error("DATA_W must hold the status bits");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must cover three registers");
   end

   spi_ctrl_t         ctrl_q;
   logic              busy, lead, trail, last;
   logic              wr_ctrl, wr_stat, wr_data;
   logic              start, coll;
   logic [NFLAG-1:0]  set_v, clr_v, flags;
   logic              sum;
   logic [DATA_W-1:0] rx_data;

   assign wr_ctrl = wr_en && (addr == ADDR_W'(ADDR_CTRL));
   assign wr_stat = wr_en && (addr == ADDR_W'(ADDR_STAT));
   assign wr_data = wr_en && (addr == ADDR_W'(ADDR_DATA));
   assign start   = wr_data && !busy;
   assign coll    = wr_data && busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl && !busy) begin
         ctrl_q.cpol <= wdata[CTL_CPOL];
         ctrl_q.cpha <= wdata[CTL_CPHA];
         ctrl_q.ie   <= wdata[CTL_IE];
      end
   end

   spi_irq_clkgen #(.DIV(DIV), .DATA_W(DATA_W)) u_clk (
      .clk(clk), .rst_n(rst_n), .start(start), .cpol(ctrl_q.cpol),
      .busy(busy), .sclk(sclk), .lead(lead), .trail(trail), .last(last)
   );

   spi_irq_shift #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .wdata(wdata),
      .cpha(ctrl_q.cpha), .lead(lead), .trail(trail), .last(last),
      .miso(miso), .mosi(mosi), .rx_data(rx_data)
   );

   always_comb begin
      set_v          = '0;
      set_v[ST_DONE] = last;
      set_v[ST_WCOL] = coll;
      set_v[ST_FLT]  = fault_in;
      clr_v          = wr_stat ? wdata[NFLAG-1:0] : '0;
   end

   spi_irq_flags #(.NF(NFLAG), .SUM_MASK(3'b011)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v),
      .ie(ctrl_q.ie), .glb_ie(glb_ie), .flag_o(flags), .sum_o(sum), .irq_o(irq)
   );

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(ADDR_CTRL)) begin
         rdata[CTL_CPOL] = ctrl_q.cpol;
         rdata[CTL_CPHA] = ctrl_q.cpha;
         rdata[CTL_IE]   = ctrl_q.ie;
      end else if (addr == ADDR_W'(ADDR_STAT)) begin
         rdata[NFLAG-1:0] = flags;
         rdata[ST_BUSY]   = busy;
         rdata[ST_SUM]    = sum;
      end else if (addr == ADDR_W'(ADDR_DATA)) begin
         rdata = rx_data;
      end
   end

   // R7: a colliding write does not cut the frame short
   a_r7_coll_keeps_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && busy && !last) |=> busy);
   // R4: serial clock rests at the programmed idle level
   a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sclk == ctrl_q.cpol));
   // R13: control cannot move under a running frame
   a_r13_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_ctrl) |=> $stable(ctrl_q));
endmodule

// File: tb/spi_irq_master_bench.sv
module spi_irq_master_bench;
   localparam int CLK_NS = 10;
   localparam int DW     = 8;
   localparam int DIV    = 4;
   localparam int HALF   = DIV / 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    addr = 2'd0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          glb_ie = 1'b0;
   logic          fault_in = 1'b0;
   logic          miso = 1'b0;
   logic          sclk, mosi, irq;
   int            checks = 0;
   int            errors = 0;

   always #(CLK_NS/2) clk = ~clk;

   spi_irq_master #(.DATA_W(DW), .DIV(DIV), .ADDR_W(2)) u_spi_irq_master (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .glb_ie(glb_ie), .fault_in(fault_in), .miso(miso),
      .sclk(sclk), .mosi(mosi), .irq(irq)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // slave model
   logic          b_cpol = 1'b0, b_cpha = 1'b0, s_act = 1'b0;
   logic [DW-1:0] s_tx = '0, s_rx = '0;
   always @(sclk) if (s_act) begin
      if (sclk != b_cpol) begin
         if (b_cpha) begin miso <= s_tx[DW-1]; s_tx <= s_tx << 1; end
         else s_rx <= {s_rx[DW-2:0], mosi};
      end else begin
         if (b_cpha) s_rx <= {s_rx[DW-2:0], mosi};
         else begin miso <= s_tx[DW-1]; s_tx <= s_tx << 1; end
      end
   end

   function automatic logic [DW-1:0] stat_exp(bit d, bit w, bit f, bit s);
      return DW'({s, 1'b0, f, w, d});
   endfunction

   task automatic wr(logic [1:0] a, logic [DW-1:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [DW-1:0] d);
      addr = a; #1; d = rdata;
   endtask

   // one frame; optional mid-frame write at negedge index mid_at
   task automatic frame(bit cpol, bit cpha, bit ie, logic [DW-1:0] mb, logic [DW-1:0] sb,
                        int mid_at, logic [1:0] mid_a, logic [DW-1:0] mid_d,
                        output logic [DW-1:0] got_s, output logic [DW-1:0] got_rx,
                        output int bcyc, output int lat);
      int n = 0, rise = 0, r8 = -1, sat = -1;
      logic prev, prev_sum;
      logic [DW-1:0] st;
      wr(2'd0, DW'({ie, cpha, cpol}));
      b_cpol = cpol; b_cpha = cpha; s_rx = '0;
      if (cpha) s_tx = sb;
      else begin miso = sb[DW-1]; s_tx = sb << 1; end
      s_act = 1'b1;
      prev = sclk;
      rd(2'd1, st); prev_sum = st[4];
      wr(2'd2, mb);
      bcyc = 0;
      forever begin
         if (n == mid_at) begin
            wr_en = 1'b1; addr = mid_a; wdata = mid_d;
            @(negedge clk); wr_en = 1'b0; n++; bcyc++;
            continue;
         end
         rd(2'd1, st);
         if (sclk && !prev) begin rise++; if (rise == 8) r8 = n; end
         prev = sclk;
         if (st[4] && !prev_sum && sat < 0) sat = n;
         prev_sum = st[4];
         if (!st[3]) break;
         bcyc++; n++;
         @(negedge clk);
      end
      s_act = 1'b0;
      got_s = s_rx;
      rd(2'd2, got_rx);
      lat = (r8 >= 0 && sat >= 0) ? sat - r8 : -1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [DW-1:0] d, gs, gr;
      int bc, lt;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(2'd0, d); chk("R1 ctrl", d, 0);
      rd(2'd1, d); chk("R1 status", d, 0);
      rd(2'd2, d); chk("R1 data", d, 0);
      chk("R1 sclk", sclk, 0); chk("R1 mosi", mosi, 0); chk("R1 irq", irq, 0);

      // R2 R3 R5 R6 R11: mode cpol0/cpha1, local enable off
      frame(0, 1, 0, 8'hA5, 8'h3C, -1, 2'd0, 8'h0, gs, gr, bc, lt);
      chk("R2 mosi byte", gs, 8'hA5);
      chk("R3 miso byte", gr, 8'h3C);
      chk("R5 busy length", bc, 8*DIV);
      chk("R6 summary latency", lt, HALF);
      rd(2'd1, d); chk("R6 R11 status after frame", d, stat_exp(1, 0, 0, 1));
      chk("R11 irq with ie off", irq, 0);
      // R12 gating
      glb_ie = 1'b1; #1; chk("R12 glb only", irq, 0);
      wr(2'd0, 8'h06); chk("R12 both enables", irq, 1);
      glb_ie = 1'b0; #1; chk("R12 local only", irq, 0);
      glb_ie = 1'b1;
      // R8 writing zero keeps flags
      wr(2'd1, 8'h00); rd(2'd1, d); chk("R8 zero write", d, stat_exp(1, 0, 0, 1));
      wr(2'd1, 8'h01); rd(2'd1, d); chk("R8 R10 done cleared", d, 0);
      chk("R12 irq drops", irq, 0);
      glb_ie = 1'b0;

      // R4 idle level
      wr(2'd0, 8'h01); chk("R4 idle high", sclk, 1);

      // R3 R4 random frames in all modes
      for (int i = 0; i < 12; i++) begin
         logic [DW-1:0] mb, sb;
         int md;
         md = $urandom % 4; mb = DW'($urandom); sb = DW'($urandom);
         if (i < 4) md = i;
         frame(md[0], md[1], 0, mb, sb, -1, 2'd0, 8'h0, gs, gr, bc, lt);
         chk("R2 R4 random mosi", gs, mb);
         chk("R3 R4 random miso", gr, sb);
         chk("R4 idle after frame", sclk, md[0]);
         wr(2'd1, 8'h07);
      end

      // R7 collision
      frame(0, 0, 0, 8'h96, 8'hE1, 6, 2'd2, 8'h0F, gs, gr, bc, lt);
      chk("R7 mosi intact", gs, 8'h96);
      chk("R7 miso intact", gr, 8'hE1);
      chk("R7 length intact", bc, 8*DIV);
      rd(2'd1, d); chk("R7 collision flag", d, stat_exp(1, 1, 0, 1));
      wr(2'd1, 8'h01); rd(2'd1, d); chk("R10 collision holds summary", d, stat_exp(0, 1, 0, 1));
      wr(2'd1, 8'h02); rd(2'd1, d); chk("R10 all clear", d, 0);

      // R9 fault alone
      @(negedge clk); fault_in = 1'b1; @(negedge clk); fault_in = 1'b0;
      rd(2'd1, d); chk("R9 fault no summary", d, stat_exp(0, 0, 1, 0));
      frame(0, 1, 0, 8'h11, 8'h22, -1, 2'd0, 8'h0, gs, gr, bc, lt);
      rd(2'd1, d); chk("R10 done with fault", d, stat_exp(1, 0, 1, 1));
      wr(2'd1, 8'h01); rd(2'd1, d); chk("R10 fault holds summary", d, stat_exp(0, 0, 1, 1));
      wr(2'd1, 8'h04); rd(2'd1, d); chk("R10 released", d, 0);

      // R8 set beats clear
      @(negedge clk); fault_in = 1'b1; wr_en = 1'b1; addr = 2'd1; wdata = 8'h04;
      @(negedge clk); fault_in = 1'b0; wr_en = 1'b0;
      rd(2'd1, d); chk("R8 set wins", d, stat_exp(0, 0, 1, 0));
      wr(2'd1, 8'h04);
      // R10 summary not writable
      wr(2'd1, 8'h10); rd(2'd1, d); chk("R10 read-only summary", d, 0);

      // R13 control frozen while busy
      frame(0, 1, 0, 8'h5A, 8'hC3, 5, 2'd0, 8'h07, gs, gr, bc, lt);
      rd(2'd0, d); chk("R13 ctrl unchanged", d, 8'h02);
      chk("R13 idle level unchanged", sclk, 0);
      chk("R13 frame intact", gs, 8'h5A);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule